// File: doc/BRIEF.md
# Open-Row Tracking Command Decoder

This block sits between a user command port and a downstream timing sequencer of a low-power DDR memory controller. It takes one user command per handshake. Each read or write becomes the shortest DRAM command sequence that the current bank state allows. Power-state commands, mode-register loads and status reads pass through as single operations. For every bank, the block remembers whether a row is open and which row it is. It compares that row with the row of each incoming access. A PRECHARGE or ACTIVE is therefore emitted only when the bank state calls for it.

The user address is split into three fields: row (top bits), bank and column (bottom bits). A decode slot one command deep sits in front of the issue stage. The next command is classified against the bank table while the previous sequence is still being handed downstream, one operation at a time, under a valid/ready handshake. The data path and the I/O cells are outside this block.

Top module: `openrow_cmd_decoder`

## Requirements
- R1: A command is taken on a rising clock edge where `cmd_valid` and `cmd_rdy` are both high. `cmd_rdy` is high exactly when the decode slot is empty or is being emptied in that cycle. Holding `cmd_valid` high with new values gives back-to-back commands.
- R2: User command codes are: 1 read, 2 write, 3 read with auto-precharge, 4 write with auto-precharge, 5 power-down entry, 6 load mode register, 7 status register read, 8 self-refresh entry, 9 self-refresh exit, 10 power-down exit, 11 deep power-down entry, 12 deep power-down exit. The main downstream operation for user code c has op code c+2.
- R3: The address is `{row, bank, column}`. The column is the low `COL_W` bits, the bank is the next `BANK_W` bits and the row is the top `ROW_W` bits. Every emitted operation carries these fields on `mem_row`, `mem_bank` and `mem_col`.
- R4: An access to a bank with no open row emits ACTIVE and then the access, both with the command's fields.
- R5: An access to a bank with a different row open emits PRECHARGE (single bank), then ACTIVE, then the access.
- R6: An access to the row already open in its bank emits only the access.
- R7: After a read or write with auto-precharge, the bank counts as closed. The next access to it starts with ACTIVE.
- R8: A power-down, self-refresh or deep power-down entry emits PRECHARGE-all first if any bank is open, then the entry operation. Afterwards all banks count as closed.
- R9: Load mode register, status read and the three exit commands emit exactly one operation each and leave the bank state unchanged.
- R10: Codes 0, 13, 14 and 15 are taken and dropped. They emit nothing, leave the bank state unchanged, and `cmd_rdy` is high in the following cycle.
- R11: One command waits in the decode slot while another is being issued. With `mem_op_ready` held low from an idle state, exactly two commands are taken.
- R12: Downstream op codes are 0 PRECHARGE, 1 PRECHARGE-all, 2 ACTIVE, 3 read, 4 write, 5 read+AP, 6 write+AP, 7 power-down entry, 8 mode load, 9 status read, 10 self-refresh entry, 11 self-refresh exit, 12 power-down exit, 13 deep power-down entry, 14 deep power-down exit. While `mem_op_valid` is high and `mem_op_ready` is low, the operation and its fields hold.
- R13: Out of reset, `cmd_rdy` is high, `mem_op_valid` is low and every bank counts as closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 4 | User command code |
| cmd_valid | input | 1 | Command and address are valid |
| addr | input | ROW_W+BANK_W+COL_W | User address `{row, bank, column}` |
| cmd_rdy | output | 1 | Decode slot can take a command |
| mem_op_valid | output | 1 | Downstream operation is presented |
| mem_op_ready | input | 1 | Sequencer takes the presented operation |
| mem_op | output | 4 | Downstream operation code |
| mem_row | output | ROW_W | Row field of the operation |
| mem_bank | output | BANK_W | Bank field of the operation |
| mem_col | output | COL_W | Column field of the operation |

## Verification
The bench covers four kinds of corner case:
- **Row hit, row miss and closed bank.** A design that compares the wrong field, or forgets the stored row, emits a spurious PRECHARGE/ACTIVE or skips a needed one.
- **Bank closing by auto-precharge and by power entry.** A design that leaves the bank marked open reissues a read without ACTIVE.
- **Illegal codes between accesses.** A design that lets them touch the table or stall the port loses the following row hit or drops `cmd_rdy`.
- **Downstream stall.** A design with no decode slot, or with a slot that overfills, takes one or three commands instead of two. A design that advances during a stall changes the presented operation.

// File: rtl/orcd_pkg.sv
// Shared types of the open-row command decoder.
// Assumes the user code and downstream op code spaces are 4 bits wide.
package orcd_pkg;

    // Downstream operation codes; a user command c maps to op c+2.
    typedef enum logic [3:0] {
        OP_PRE  = 4'd0,
        OP_PREA = 4'd1,
        OP_ACT  = 4'd2,
        OP_RD   = 4'd3,
        OP_WR   = 4'd4,
        OP_RDA  = 4'd5,
        OP_WRA  = 4'd6,
        OP_PDE  = 4'd7,
        OP_MRS  = 4'd8,
        OP_SRR  = 4'd9,
        OP_SRE  = 4'd10,
        OP_SRX  = 4'd11,
        OP_PDX  = 4'd12,
        OP_DPDE = 4'd13,
        OP_DPDX = 4'd14
    } mem_op_e;

    // User command codes.
    localparam logic [3:0] UC_RD   = 4'd1;
    localparam logic [3:0] UC_WR   = 4'd2;
    localparam logic [3:0] UC_RDA  = 4'd3;
    localparam logic [3:0] UC_WRA  = 4'd4;
    localparam logic [3:0] UC_PDE  = 4'd5;
    localparam logic [3:0] UC_MRS  = 4'd6;
    localparam logic [3:0] UC_SRR  = 4'd7;
    localparam logic [3:0] UC_SRE  = 4'd8;
    localparam logic [3:0] UC_SRX  = 4'd9;
    localparam logic [3:0] UC_PDX  = 4'd10;
    localparam logic [3:0] UC_DPDE = 4'd11;
    localparam logic [3:0] UC_DPDX = 4'd12;

    // How a taken command changes the bank table.
    typedef enum logic [1:0] {
        UPD_NONE      = 2'd0,
        UPD_OPEN      = 2'd1,
        UPD_CLOSE_ONE = 2'd2,
        UPD_CLOSE_ALL = 2'd3
    } tbl_upd_e;

    // Decoded sequence: remaining steps, issued in order pre, act, main.
    typedef struct packed {
        logic    do_pre;
        logic    pre_all;
        logic    do_act;
        logic    do_main;
        mem_op_e main_op;
    } plan_t;

endpackage

// File: rtl/orcd_addr_split.sv
// Splits a flat user address into row, bank and column fields.
// Assumes the layout {row, bank, column} with the column in the low bits.
module orcd_addr_split #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);
    // Field extraction by position.
    assign col  = addr[COL_W-1:0];
    assign bank = addr[COL_W +: BANK_W];
    assign row  = addr[COL_W+BANK_W +: ROW_W];
endmodule

// File: rtl/orcd_bank_table.sv
// Per-bank open flag and open-row register, with one lookup port.
// Assumes at most one update per cycle, applied at the clock edge.
module orcd_bank_table
    import orcd_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_hit,
    output logic              any_open,
    input  logic              upd_en,
    input  tbl_upd_e          upd_kind,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    logic [NB-1:0]    open_vec;
    logic [ROW_W-1:0] rows [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic             open_b;
        logic [ROW_W-1:0] row_b;
        logic             sel;

        assign sel = (upd_bank == BANK_W'(g));

        // Update this bank's entry from the command being taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_b <= 1'b0;
                row_b  <= '0;
            end else if (upd_en) begin
                case (upd_kind)
                    UPD_OPEN: if (sel) begin
                        open_b <= 1'b1;
                        row_b  <= upd_row;
                    end
                    UPD_CLOSE_ONE: if (sel) open_b <= 1'b0;
                    UPD_CLOSE_ALL: open_b <= 1'b0;
                    default: ;
                endcase
            end
        end

        assign open_vec[g] = open_b;
        assign rows[g]     = row_b;
    end

    // Lookup of the addressed bank.
    assign lk_open  = open_vec[lk_bank];
    assign lk_hit   = lk_open && (rows[lk_bank] == lk_row);
    assign any_open = |open_vec;
endmodule

// File: rtl/orcd_issue.sv
// Decode slot plus issue stage: holds one decoded command while the
// previous sequence is handed downstream one step per accepted cycle.
// Assumes in_take is only raised while slot_free is high.
module orcd_issue
    import orcd_pkg::*;
#(
    parameter int ADDR_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_take,
    input  plan_t             in_plan,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              slot_free,
    output logic              op_valid,
    input  logic              op_ready,
    output mem_op_e           op_code,
    output logic [ADDR_W-1:0] op_addr
);
    logic              pend_v;
    plan_t             pend_plan;
    logic [ADDR_W-1:0] pend_addr;
    plan_t             cur_plan;
    logic [ADDR_W-1:0] cur_addr;
    plan_t             cur_next;
    logic              cur_busy, fire, finishing, load;

    assign cur_busy = cur_plan.do_pre | cur_plan.do_act | cur_plan.do_main;
    assign fire     = cur_busy && op_ready;

    // Step removal: the earliest remaining step leaves first.
    always_comb begin
        cur_next = cur_plan;
        if (cur_plan.do_pre)      cur_next.do_pre  = 1'b0;
        else if (cur_plan.do_act) cur_next.do_act  = 1'b0;
        else                      cur_next.do_main = 1'b0;
    end

    assign finishing = fire && !(cur_next.do_pre | cur_next.do_act | cur_next.do_main);
    assign load      = pend_v && (!cur_busy || finishing);
    assign slot_free = !pend_v || load;

    // Decode slot: filled on a take, emptied when moved to issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_plan <= '0;
            pend_addr <= '0;
        end else if (in_take) begin
            pend_v    <= 1'b1;
            pend_plan <= in_plan;
            pend_addr <= in_addr;
        end else if (load) begin
            pend_v    <= 1'b0;
        end
    end

    // Issue stage: load the next sequence or retire one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_plan <= '0;
            cur_addr <= '0;
        end else if (load) begin
            cur_plan <= pend_plan;
            cur_addr <= pend_addr;
        end else if (fire) begin
            cur_plan <= cur_next;
        end
    end

    // Presented operation follows the earliest remaining step.
    always_comb begin
        if (cur_plan.do_pre)      op_code = cur_plan.pre_all ? OP_PREA : OP_PRE;
        else if (cur_plan.do_act) op_code = OP_ACT;
        else                      op_code = cur_plan.main_op;
    end

    assign op_valid = cur_busy;
    assign op_addr  = cur_addr;
endmodule

// File: rtl/openrow_cmd_decoder.sv
// Open-row tracking command decoder. Classifies each taken user command
// against the bank table, updates the table at once, and queues the
// resulting step plan for issue to a downstream timing sequencer.
// Assumes the sequencer enforces all DRAM timing between operations.
module openrow_cmd_decoder
    import orcd_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 10,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_rdy,
    output logic              mem_op_valid,
    input  logic              mem_op_ready,
    output logic [3:0]        mem_op,
    output logic [ROW_W-1:0]  mem_row,
    output logic [BANK_W-1:0] mem_bank,
    output logic [COL_W-1:0]  mem_col
);
    logic [ROW_W-1:0]  in_row;
    logic [BANK_W-1:0] in_bank;
    logic [COL_W-1:0]  in_col;
    logic              bk_open, bk_hit, bk_any;
    logic              legal, take;
    plan_t             plan;
    tbl_upd_e          upd_kind;
    mem_op_e           op_code;
    logic [ADDR_W-1:0] op_addr;

    orcd_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_in_split (
        .addr (addr),
        .row  (in_row),
        .bank (in_bank),
        .col  (in_col)
    );

    orcd_bank_table #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (in_bank),
        .lk_row   (in_row),
        .lk_open  (bk_open),
        .lk_hit   (bk_hit),
        .any_open (bk_any),
        .upd_en   (take),
        .upd_kind (upd_kind),
        .upd_bank (in_bank),
        .upd_row  (in_row)
    );

    // Command classification into a step plan and a table update.
    always_comb begin
        plan     = '0;
        upd_kind = UPD_NONE;
        legal    = 1'b1;
        case (cmd)
            UC_RD, UC_WR, UC_RDA, UC_WRA: begin
                plan.do_pre = bk_open && !bk_hit;
                plan.do_act = !bk_hit;
                upd_kind    = (cmd == UC_RD || cmd == UC_WR) ? UPD_OPEN : UPD_CLOSE_ONE;
            end
            UC_PDE, UC_SRE, UC_DPDE: begin
                plan.do_pre  = bk_any;
                plan.pre_all = 1'b1;
                upd_kind     = UPD_CLOSE_ALL;
            end
            UC_MRS, UC_SRR, UC_SRX, UC_PDX, UC_DPDX: ;
            default: legal = 1'b0;
        endcase
        plan.do_main = legal;
        plan.main_op = legal ? mem_op_e'(cmd + 4'd2) : OP_PRE;
    end

    assign take = cmd_valid && cmd_rdy && legal;

    orcd_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_take   (take),
        .in_plan   (plan),
        .in_addr   (addr),
        .slot_free (cmd_rdy),
        .op_valid  (mem_op_valid),
        .op_ready  (mem_op_ready),
        .op_code   (op_code),
        .op_addr   (op_addr)
    );

    orcd_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_out_split (
        .addr (op_addr),
        .row  (mem_row),
        .bank (mem_bank),
        .col  (mem_col)
    );

    assign mem_op = op_code;
endmodule

// File: rtl/orcd_checks.sv
// Protocol checks for the open-row command decoder, attached by bind.
// Assumes it observes only the top-level ports.
module orcd_checks
    import orcd_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd,
    input logic              cmd_valid,
    input logic              cmd_rdy,
    input logic              mem_op_valid,
    input logic              mem_op_ready,
    input logic [3:0]        mem_op,
    input logic [ROW_W-1:0]  mem_row,
    input logic [BANK_W-1:0] mem_bank,
    input logic [COL_W-1:0]  mem_col
);
    logic hs;
    assign hs = mem_op_valid && mem_op_ready;

    // A stalled operation and its fields stay put.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_op_valid && !mem_op_ready |=> mem_op_valid && $stable(mem_op)
            && $stable(mem_row) && $stable(mem_bank) && $stable(mem_col));

    // ACTIVE is always followed by the access to the same bank and row.
    assert_act_then_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs && mem_op == OP_ACT |=> mem_op_valid && mem_op >= OP_RD && mem_op <= OP_WRA
            && $stable(mem_bank) && $stable(mem_row));

    // Single-bank PRECHARGE is always followed by ACTIVE to that bank.
    assert_pre_then_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hs && mem_op == OP_PRE |=> mem_op_valid && mem_op == OP_ACT && $stable(mem_bank));

    // PRECHARGE-all is always followed by a power-state entry.
    assert_prea_then_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hs && mem_op == OP_PREA |=> mem_op_valid
            && (mem_op == OP_PDE || mem_op == OP_SRE || mem_op == OP_DPDE));

    // An illegal code does not occupy the decode slot.
    assert_illegal_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_rdy && (cmd == 4'd0 || cmd > 4'd12) |=> cmd_rdy);
endmodule

bind openrow_cmd_decoder orcd_checks #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .cmd_valid    (cmd_valid),
    .cmd_rdy      (cmd_rdy),
    .mem_op_valid (mem_op_valid),
    .mem_op_ready (mem_op_ready),
    .mem_op       (mem_op),
    .mem_row      (mem_row),
    .mem_bank     (mem_bank),
    .mem_col      (mem_col)
);

// File: tb/sim_openrow_cmd_decoder.sv
// Bench: behavioural bank model and expected-operation queue,
// compared with the downstream port every clock.
module sim_openrow_cmd_decoder;
    localparam int ROW_W = 13, BANK_W = 2, COL_W = 10;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int NB = 4;
    localparam int E_PRE = 0, E_PREA = 1, E_ACT = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [3:0]        cmd;
    logic              cmd_valid;
    logic [ADDR_W-1:0] addr;
    logic              cmd_rdy;
    logic              mem_op_valid;
    logic              mem_op_ready;
    logic [3:0]        mem_op;
    logic [ROW_W-1:0]  mem_row;
    logic [BANK_W-1:0] mem_bank;
    logic [COL_W-1:0]  mem_col;

    openrow_cmd_decoder #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_valid(cmd_valid), .addr(addr),
        .cmd_rdy(cmd_rdy), .mem_op_valid(mem_op_valid), .mem_op_ready(mem_op_ready),
        .mem_op(mem_op), .mem_row(mem_row), .mem_bank(mem_bank), .mem_col(mem_col)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, ready_mode = 0;
    logic [3+ADDR_W:0] expq[$];
    string             tagq[$];
    logic              m_open [NB];
    logic [ROW_W-1:0]  m_row  [NB];
    string             m_why  [NB];
    bit                finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int r, input int b, input int c);
        return {ROW_W'(r), BANK_W'(b), COL_W'(c)};
    endfunction

    function automatic void push(input int op, input logic [ADDR_W-1:0] a, input string t);
        expq.push_back({op[3:0], a});
        tagq.push_back(t);
    endfunction

    // Reference behaviour of one taken command.
    function automatic void model_take(input logic [3:0] c, input logic [ADDR_W-1:0] a);
        int b = int'(a[COL_W +: BANK_W]);
        logic [ROW_W-1:0] r = a[COL_W+BANK_W +: ROW_W];
        bit any = 0;
        for (int i = 0; i < NB; i++) any |= m_open[i];
        case (c)
            4'd1, 4'd2, 4'd3, 4'd4: begin
                if (!m_open[b]) begin
                    push(E_ACT, a, m_why[b]);
                    push(int'(c) + 2, a, "R3");
                end else if (m_row[b] != r) begin
                    push(E_PRE, a, "R5");
                    push(E_ACT, a, "R5");
                    push(int'(c) + 2, a, "R3");
                end else begin
                    push(int'(c) + 2, a, "R6");
                end
                if (c <= 4'd2) begin
                    m_open[b] = 1; m_row[b] = r;
                end else begin
                    m_open[b] = 0; m_why[b] = "R7";
                end
            end
            4'd5, 4'd8, 4'd11: begin
                if (any) push(E_PREA, a, "R8");
                push(int'(c) + 2, a, "R8");
                for (int i = 0; i < NB; i++) begin
                    m_open[i] = 0; m_why[i] = "R8";
                end
            end
            4'd6, 4'd7, 4'd9, 4'd10, 4'd12: push(int'(c) + 2, a, "R9");
            default: ;
        endcase
    endfunction

    // Present one command and hold it until taken (R1).
    task automatic send(input logic [3:0] c, input logic [ADDR_W-1:0] a);
        cmd_valid = 1; cmd = c; addr = a;
        #4;
        while (!cmd_rdy) begin
            @(negedge clk); #4;
        end
        model_take(c, a);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((expq.size() != 0 || mem_op_valid) && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    // Downstream ready pattern: always, pseudo-random, or stalled.
    initial begin
        logic [15:0] lf = 16'hACE1;
        mem_op_ready = 1'b0;
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mem_op_ready = (ready_mode == 0) ? 1'b1 :
                           (ready_mode == 1) ? (lf[0] | lf[3]) : 1'b0;
        end
    end

    // Per-cycle comparison of the downstream port against the model.
    initial begin
        bit                prev_stall = 0;
        logic [3+ADDR_W:0] prev;
        logic [3+ADDR_W:0] got, exp;
        string             t;
        forever begin
            @(negedge clk); #6;
            if (!rst_n) begin
                prev_stall = 0;
                continue;
            end
            got = {mem_op, mem_row, mem_bank, mem_col};
            if (prev_stall)
                chk(mem_op_valid && got == prev, "R12", "stalled op changed", 64'(got), 64'(prev));
            if (mem_op_valid && mem_op_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R1", "unexpected op", 64'(got), 64'hF);
                end else begin
                    exp = expq.pop_front();
                    t = tagq.pop_front();
                    if (int'(exp[3+ADDR_W:ADDR_W]) == E_PREA)
                        chk(mem_op == 4'(E_PREA), t, "prechargeall op", 64'(mem_op), 64'(E_PREA));
                    else
                        chk(got == exp, t, "op/fields", 64'(got), 64'(exp));
                end
            end
            prev_stall = mem_op_valid && !mem_op_ready;
            prev = got;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0; m_row[i] = '0; m_why[i] = "R4";
        end
        rst_n = 0; cmd_valid = 0; cmd = 0; addr = '0;
        repeat (4) @(negedge clk);
        #4;
        chk(cmd_rdy == 1'b1, "R13", "cmd_rdy in reset", 64'(cmd_rdy), 1);
        chk(mem_op_valid == 1'b0, "R13", "op valid in reset", 64'(mem_op_valid), 0);
        @(negedge clk);
        rst_n = 1;
        #4;
        chk(cmd_rdy == 1'b1, "R13", "cmd_rdy after reset", 64'(cmd_rdy), 1);
        @(negedge clk);

        // Closed bank, hit, miss (R4 R6 R5), with R2 R3 codes and fields.
        send(4'd1, mk(5, 0, 3));
        send(4'd1, mk(5, 0, 7));
        send(4'd2, mk(9, 0, 1));
        // Auto-precharge closes the bank (R7).
        send(4'd3, mk(3, 1, 2));
        send(4'd1, mk(3, 1, 4));
        send(4'd4, mk(9, 0, 5));
        send(4'd2, mk(9, 0, 6));
        drain();
        // Illegal codes are dropped (R10): slot stays free, table unchanged.
        send(4'd0, mk(2, 0, 0));
        #4 chk(cmd_rdy == 1'b1, "R10", "cmd_rdy after code 0", 64'(cmd_rdy), 1);
        @(negedge clk);
        send(4'd13, mk(2, 0, 0));
        send(4'd14, mk(7, 0, 0));
        send(4'd15, mk(1, 0, 0));
        #4 chk(cmd_rdy == 1'b1, "R10", "cmd_rdy after code 15", 64'(cmd_rdy), 1);
        @(negedge clk);
        send(4'd1, mk(9, 0, 8));   // R10: still a hit on row 9
        // Single-operation pass-through (R9).
        send(4'd6, mk(12'h155, 0, 10'h2A));
        send(4'd7, mk(0, 2, 1));
        send(4'd1, mk(4, 3, 0));
        // Power entries with open banks, and exits (R8 R9).
        send(4'd5, mk(0, 0, 0));
        send(4'd10, mk(0, 0, 0));
        send(4'd1, mk(9, 0, 1));
        send(4'd8, mk(0, 0, 0));
        send(4'd9, mk(0, 0, 0));
        send(4'd11, mk(0, 0, 0));  // nothing open: no precharge-all
        send(4'd12, mk(0, 0, 0));
        drain();
        chk(expq.size() == 0, "R9", "directed ops outstanding", expq.size(), 0);

        // Decode-ahead depth under a stalled sequencer (R11).
        ready_mode = 2;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cmd_valid = 1; cmd = 4'd1; addr = mk(1, i % NB, i);
            #4;
            if (cmd_rdy) begin
                model_take(cmd, addr);
                cnt++;
            end
        end
        @(negedge clk);
        cmd_valid = 0;
        chk(cnt == 2, "R11", "commands taken while stalled", cnt, 2);
        ready_mode = 0;
        drain();

        // Random stream with random downstream stalls.
        ready_mode = 1;
        for (int i = 0; i < 400; i++)
            send(4'($urandom_range(0, 15)),
                 mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1023)));
        ready_mode = 0;
        drain();
        chk(expq.size() == 0, "R11", "random ops outstanding", expq.size(), 0);
        chk(mem_op_valid == 1'b0, "R1", "idle at end", 64'(mem_op_valid), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule